// File: doc/BRIEF.md
# Interrupt Distributor with Priority Arbitration

This block collects a set of raw interrupt request lines and delivers each one to a single processor. Software configures it through a 32-bit word-addressed register port. Each interrupt ID has its own enable bit, a priority, a mask of target CPUs and a sensitivity setting. A global enable bit gates delivery as a whole.

Each request line is captured as pending in one of two ways. A level-type ID follows its input line. An edge-type ID latches a rising transition until that ID is acknowledged. For each CPU, the block presents the most urgent interrupt that is enabled, pending and not already in service. An acknowledge strobe returns that ID and marks it active. An end-of-interrupt strobe carrying the same ID returns it to the idle state.

With the default parameters (64 IDs, 2 CPUs) the register word offsets are as follows: control at 0, enables at 1–2, priorities at 3–18, targets at 19–34 and sensitivity at 35–38. Each bank grows with the ID count and packs its fields as listed below.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the control word and all enable bits read 0, and no CPU interrupt output is asserted.
- R2: Bit 0 of word 0 is the global enable. While it is 0, no CPU interrupt output is asserted, and pending state is kept.
- R3: The priority of an ID is held in byte lane (id mod 4) of word 3+id/4. Only bits 7:3 are stored, and bits 2:0 always read 0. The result is 32 levels in steps of 8.
- R4: The target mask of an ID is held in byte lane (id mod 4) of word 19+id/4. Bit n selects CPU n, and unimplemented bits read 0. An interrupt is presented only to the lowest-numbered CPU whose target bit is set.
- R5: The sensitivity field of an ID is at bits (id mod 16)*2+1:(id mod 16)*2 of word 35+id/16. For IDs 16 and up, the low bit always reads 1, and the writable high bit selects the type: 01 is level, 11 is rising edge. Word 35 (IDs 0–15) always reads 0xAAAAAAAA (edge), and writes to it are ignored.
- R6: For an edge ID, a 0-to-1 transition on its request line sets pending. Pending stays set after the line falls and is cleared by acknowledging the ID.
- R7: For a level ID, pending follows the request line. When the line drops, the interrupt is withdrawn.
- R8: A CPU is offered the candidate with the numerically lowest priority. When priorities are equal, the lower ID wins.
- R9: An acknowledge returns the offered ID and marks it active. An active ID is not offered again, even if its level line stays high, until an end-of-interrupt strobe carrying that ID arrives.
- R10: An acknowledge when the CPU has no candidate returns 1023 and changes no state.
- R11: The enable bit of an ID is bit (id mod 32) of word 1+id/32. A disabled ID is not offered, but its edge pending is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| irq_req_i | input | NUM_IDS | Raw interrupt request lines |
| irq_o | output | NUM_CPUS | Per-CPU interrupt presented |
| ack_i | input | NUM_CPUS | Per-CPU acknowledge strobe |
| ack_id_o | output | NUM_CPUS*10 | Per-CPU ID returned by the last acknowledge |
| eoi_i | input | NUM_CPUS | Per-CPU end-of-interrupt strobe |
| eoi_id_i | input | NUM_CPUS*10 | Per-CPU ID being completed |

## Verification
The bench uses the defaults of 64 IDs and 2 CPUs. This size brings a fixed sensitivity word (IDs 0–15) and writable sensitivity words together in one run. It also spreads the used IDs across lanes of several priority and target words. With two CPUs, the bench can observe that a doubly-targeted interrupt reaches only CPU 0, that a CPU-1-only interrupt reaches CPU 1, and that a CPU with nothing to take receives the spurious code.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int unsigned ID_W      = 10;
  localparam int unsigned PRIO_W    = 5;
  localparam int unsigned FIXED_IDS = 16;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  function automatic int unsigned words_total(int unsigned n);
    return 1 + n / 32 + 2 * (n / 4) + n / 16;
  endfunction

  function automatic int unsigned addr_w(int unsigned n);
    return $clog2(words_total(n));
  endfunction
endpackage

// File: rtl/dist_regs.sv
module dist_regs
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [31:0]                          wdata_i,
  output logic [31:0]                          rdata_o,
  output logic                                 ctrl_en_o,
  output logic [NUM_IDS-1:0]                   en_o,
  output logic [NUM_IDS-1:0]                   edge_o,
  output logic [NUM_IDS-1:0][PRIO_W-1:0]       prio_o,
  output logic [NUM_IDS-1:0][NUM_CPUS-1:0]     tgt_o
);
  localparam int unsigned ENA_BASE  = 1;
  localparam int unsigned PRIO_BASE = ENA_BASE + NUM_IDS / 32;
  localparam int unsigned TGT_BASE  = PRIO_BASE + NUM_IDS / 4;
  localparam int unsigned SENS_BASE = TGT_BASE + NUM_IDS / 4;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_en_o <= 1'b0;
    else if (we_i && addr_i == '0) ctrl_en_o <= wdata_i[0];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    logic                en_r;
    logic [PRIO_W-1:0]   prio_r;
    logic [NUM_CPUS-1:0] tgt_r;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        en_r   <= 1'b0;
        prio_r <= '0;
        tgt_r  <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_W'(ENA_BASE + g / 32))  en_r   <= wdata_i[g % 32];
        if (addr_i == ADDR_W'(PRIO_BASE + g / 4))  prio_r <= wdata_i[(g % 4) * 8 + 3 +: PRIO_W];
        if (addr_i == ADDR_W'(TGT_BASE + g / 4))   tgt_r  <= wdata_i[(g % 4) * 8 +: NUM_CPUS];
      end

    assign en_o[g]   = en_r;
    assign prio_o[g] = prio_r;
    assign tgt_o[g]  = tgt_r;

    if (g < FIXED_IDS) begin : g_fixed
      assign edge_o[g] = 1'b1;
    end else begin : g_cfg
      logic edge_r;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) edge_r <= 1'b0;
        else if (we_i && addr_i == ADDR_W'(SENS_BASE + g / 16))
          edge_r <= wdata_i[(g % 16) * 2 + 1];
      assign edge_o[g] = edge_r;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[0] = ctrl_en_o;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (addr_i == ADDR_W'(ENA_BASE + i / 32))  rdata_o[i % 32] = en_o[i];
      if (addr_i == ADDR_W'(PRIO_BASE + i / 4))  rdata_o[(i % 4) * 8 +: 8] = {prio_o[i], 3'b000};
      if (addr_i == ADDR_W'(TGT_BASE + i / 4))   rdata_o[(i % 4) * 8 +: 8] = 8'(tgt_o[i]);
      if (addr_i == ADDR_W'(SENS_BASE + i / 16)) rdata_o[(i % 16) * 2 +: 2] =
                                                   (i < FIXED_IDS) ? 2'b10 : {edge_o[i], 1'b1};
    end
  end
endmodule

// File: rtl/dist_pending.sv
module dist_pending #(
  parameter int unsigned NUM_IDS = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IDS-1:0] req_i,
  input  logic [NUM_IDS-1:0] edge_i,
  input  logic [NUM_IDS-1:0] clr_i,
  output logic [NUM_IDS-1:0] pend_o
);
  logic [NUM_IDS-1:0] req_q;
  logic [NUM_IDS-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q <= req_i;
      for (int i = 0; i < NUM_IDS; i++) begin
        if (!edge_i[i])                pend_q[i] <= req_i[i];
        else if (req_i[i] && !req_q[i]) pend_q[i] <= 1'b1;   // new edge beats ack
        else if (clr_i[i])              pend_q[i] <= 1'b0;
      end
    end

  assign pend_o = pend_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_chk
    AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_i[g] && req_i[g] && !req_q[g] |=> pend_q[g]); // R6
  end
endmodule

// File: rtl/dist_select.sv
module dist_select
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IDS = 64,
  parameter int unsigned IDX_W   = $clog2(NUM_IDS)
) (
  input  logic [NUM_IDS-1:0]             cand_i,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower ID on a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < NUM_IDS; i++)
      if (cand_i[i] && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        idx_o   = IDX_W'(i);
      end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned ADDR_W   = dist_pkg::addr_w(NUM_IDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  input  logic [NUM_IDS-1:0]       irq_req_i,
  output logic [NUM_CPUS-1:0]      irq_o,
  input  logic [NUM_CPUS-1:0]      ack_i,
  output logic [NUM_CPUS*ID_W-1:0] ack_id_o,
  input  logic [NUM_CPUS-1:0]      eoi_i,
  input  logic [NUM_CPUS*ID_W-1:0] eoi_id_i
);
  localparam int unsigned IDX_W = $clog2(NUM_IDS);

  logic                               ctrl_en;
  logic [NUM_IDS-1:0]                 en, edge_sel, pend, active_q, ack_hit, eoi_hit;
  logic [NUM_IDS-1:0][PRIO_W-1:0]     prio;
  logic [NUM_IDS-1:0][NUM_CPUS-1:0]   tgt;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]   route, cand;
  logic [NUM_CPUS-1:0]                sel_valid;
  logic [NUM_CPUS-1:0][IDX_W-1:0]     sel_idx;

  dist_regs #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ctrl_en_o(ctrl_en), .en_o(en), .edge_o(edge_sel),
    .prio_o(prio), .tgt_o(tgt));

  dist_pending #(.NUM_IDS(NUM_IDS)) i_pending (
    .clk_i, .rst_ni, .req_i(irq_req_i), .edge_i(edge_sel), .clr_i(ack_hit), .pend_o(pend));

  // each ID is routed to its lowest-numbered targeted CPU only
  always_comb
    for (int i = 0; i < NUM_IDS; i++) begin
      logic seen;
      seen = 1'b0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        route[c][i] = tgt[i][c] && !seen;
        seen        = seen | tgt[i][c];
      end
    end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign cand[c] = route[c] & en & pend & ~active_q & {NUM_IDS{ctrl_en}};

    dist_select #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) i_select (
      .cand_i(cand[c]), .prio_i(prio), .valid_o(sel_valid[c]), .idx_o(sel_idx[c]));

    assign irq_o[c] = sel_valid[c];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) ack_id_o[c*ID_W +: ID_W] <= SPURIOUS_ID;
      else if (ack_i[c])
        ack_id_o[c*ID_W +: ID_W] <= sel_valid[c] ? ID_W'(sel_idx[c]) : SPURIOUS_ID;

    AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[c] && sel_valid[c] |=> active_q[$past(sel_idx[c])]); // R9
    AST_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[c] && !sel_valid[c] |=> ack_id_o[c*ID_W +: ID_W] == SPURIOUS_ID); // R10
  end

  always_comb begin
    ack_hit = '0;
    eoi_hit = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (ack_i[c] && sel_valid[c]) ack_hit[sel_idx[c]] = 1'b1;
      for (int i = 0; i < NUM_IDS; i++)
        if (eoi_i[c] && eoi_id_i[c*ID_W +: ID_W] == ID_W'(i)) eoi_hit[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) active_q <= '0;
    else         active_q <= ack_hit | (active_q & ~eoi_hit);

  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |-> irq_o == '0); // R2

  if (NUM_CPUS >= 2) begin : g_single
    AST_SINGLE_DELIVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sel_valid[0] && sel_valid[1] && sel_idx[0] == sel_idx[1])); // R4
  end
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
  localparam int CLK_PERIOD = 10;
  localparam int NIDS = 64;
  localparam int NCPU = 2;
  localparam int IDW  = 10;
  localparam int A_CTRL = 0, A_ENA = 1, A_PRIO = 3, A_TGT = 19, A_SENS = 35;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NIDS-1:0] req = '0;
  logic [NCPU-1:0] irq, ack = '0, eoi = '0;
  logic [NCPU*IDW-1:0] ack_id, eoi_id = '0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] ena_shadow = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor #(.NUM_IDS(NIDS), .NUM_CPUS(NCPU)) i_irq_distributor (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_i(req), .irq_o(irq), .ack_i(ack), .ack_id_o(ack_id),
    .eoi_i(eoi), .eoi_id_i(eoi_id));

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 6'(a); wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); addr = 6'(a); #1 d = rdata;
  endtask

  task automatic set_byte(int base, int id, logic [7:0] v);
    logic [31:0] d;
    rd(base + id / 4, d);
    d[(id % 4) * 8 +: 8] = v;
    wr(base + id / 4, d);
  endtask

  task automatic pulse(int id);
    @(negedge clk); req[id] = 1'b1;
    @(negedge clk); req[id] = 1'b0;
  endtask

  task automatic do_ack(int c, output int id);
    @(negedge clk); ack[c] = 1'b1;
    @(posedge clk);
    @(negedge clk); ack[c] = 1'b0;
    id = int'(ack_id[c*IDW +: IDW]);
  endtask

  task automatic do_eoi(int c, int id);
    @(negedge clk); eoi[c] = 1'b1; eoi_id[c*IDW +: IDW] = IDW'(id);
    @(posedge clk);
    @(negedge clk); eoi[c] = 1'b0;
  endtask

  task automatic chk_irq(string r, logic [NCPU-1:0] exp);
    @(negedge clk); #1 check(r, 32'(irq), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int id;
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_ENA, d);  check("R1 enable", d, 0);
    chk_irq("R1 irq", 2'b00);
    do_ack(0, id); check("R10 spurious", id, 1023);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_PRIO, 32'hFFFF_FFFF); rd(A_PRIO, d); check("R3 prio low bits", d, 32'hF8F8_F8F8);
    wr(A_PRIO + 1, 32'h1234_5678); rd(A_PRIO + 1, d); check("R3 prio lanes", d, 32'h1030_5078);
    wr(A_TGT, 32'hFFFF_FFFF); rd(A_TGT, d); check("R4 target bits", d, 32'h0303_0303);
    wr(A_SENS, 32'h0); rd(A_SENS, d); check("R5 fixed edge word", d, 32'hAAAA_AAAA);
    wr(A_SENS + 2, 32'h0); rd(A_SENS + 2, d); check("R5 level readback", d, 32'h5555_5555);
    wr(A_SENS + 2, 32'hFFFF_FFFF); rd(A_SENS + 2, d); check("R5 edge readback", d, 32'hFFFF_FFFF);
    wr(A_SENS + 2, 32'hFFFF_FFF7); rd(A_SENS + 2, d); check("R5 id33 level", d, 32'hFFFF_FFF7);
  endtask

  task automatic setup;
    for (int i = 33; i <= 43; i++) set_byte(A_TGT, i, 8'h01);
    set_byte(A_TGT, 41, 8'h03);
    set_byte(A_TGT, 42, 8'h02);
    ena_shadow = 32'h0000_073E;
    wr(A_ENA + 1, ena_shadow);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic t_edge;
    int id;
    pulse(40);
    chk_irq("R6 edge held after fall", 2'b01);
    do_ack(0, id); check("R9 ack id", id, 40);
    chk_irq("R6 cleared by ack", 2'b00);
    do_eoi(0, 40);
    chk_irq("R6 no re-trigger", 2'b00);
  endtask

  task automatic t_level;
    int id;
    @(negedge clk); req[33] = 1'b1;
    chk_irq("R7 level presented", 2'b01);
    do_ack(0, id); check("R9 level ack", id, 33);
    chk_irq("R9 active blocks", 2'b00);
    do_eoi(0, 33);
    #1 check("R9 re-present after eoi", 32'(irq), 32'h1);
    @(negedge clk); req[33] = 1'b0;
    chk_irq("R7 line dropped", 2'b00);
  endtask

  task automatic t_prio;
    int id;
    set_byte(A_PRIO, 34, 8'h40);
    set_byte(A_PRIO, 35, 8'h20);
    @(negedge clk); req[34] = 1'b1; req[35] = 1'b1;
    @(negedge clk); req[34] = 1'b0; req[35] = 1'b0;
    do_ack(0, id); check("R8 lower value first", id, 35);
    do_ack(0, id); check("R8 then next", id, 34);
    do_eoi(0, 35); do_eoi(0, 34);
    set_byte(A_PRIO, 36, 8'h10);
    set_byte(A_PRIO, 37, 8'h10);
    @(negedge clk); req[36] = 1'b1; req[37] = 1'b1;
    @(negedge clk); req[36] = 1'b0; req[37] = 1'b0;
    do_ack(0, id); check("R8 tie lower id", id, 36);
    do_ack(0, id); check("R8 tie second", id, 37);
    do_eoi(0, 36); do_eoi(0, 37);
  endtask

  task automatic t_target;
    int id;
    pulse(41);
    chk_irq("R4 lowest target only", 2'b01);
    do_ack(1, id); check("R4 cpu1 gets nothing", id, 1023);
    do_ack(0, id); check("R4 cpu0 ack", id, 41);
    do_eoi(0, 41);
    pulse(42);
    chk_irq("R4 cpu1 target", 2'b10);
    do_ack(1, id); check("R4 cpu1 ack", id, 42);
    do_eoi(1, 42);
    chk_irq("R4 idle", 2'b00);
  endtask

  task automatic t_enable;
    int id;
    pulse(43);
    chk_irq("R11 disabled not offered", 2'b00);
    ena_shadow[11] = 1'b1;
    wr(A_ENA + 1, ena_shadow);
    chk_irq("R11 retained pending", 2'b01);
    wr(A_CTRL, 32'h0);
    chk_irq("R2 global off", 2'b00);
    wr(A_CTRL, 32'h1);
    do_ack(0, id); check("R2 kept pending", id, 43);
    do_eoi(0, 43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    setup();
    t_edge();
    t_level();
    t_prio();
    t_target();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule